// File: doc/BRIEF.md
# Pulse-Width Sensor Bus Frame Engine

This block drives one command frame onto a sensor bus whose data line carries bits as low pulses of different widths, and while doing so it samples the return line once per bit. A frame is framed by an active-low frame line. The first bit slot is a lead slot in which the data line stays idle. The data word follows, most significant bit first, and is followed at once by a CRC over that word, also most significant bit first. The return line is sampled in the last clock cycle of every data and CRC bit slot. The received CRC bits are checked against a CRC computed over the received data bits.

All timing is counted in cycles of the fast internal clock. One bit slot lasts `320 + 2*sel` cycles, where `sel` is an 8-bit period select. A one is a low pulse of a third of the slot, rounded down. A zero is a low pulse twice that length. Data length, CRC length, period select and minimum inter-frame gap are sampled when a frame is accepted and held for that frame. After the frame line rises, a one-cycle done pulse marks the point where the received word and the error flag are valid. The gap rule then keeps the frame line high until the programmed minimum has elapsed.

Top module: `psb_frame_engine`

## Requirements
- R1: After a synchronous reset, frame_n=1, dout=1, ready=1, done=0, rx_data=0 and rx_crc_err=0.
- R2: When start is high on a clock edge with ready high, frame_n is low from the next cycle. tx_data, data_len, crc_len, period_sel and gap_cfg are captured at that edge, and later changes to them do not alter the frame in progress.
- R3: Outside a frame dout is high. Inside a frame, dout stays high for exactly P cycles after frame_n falls (the lead slot). P = 320 + 2*period_sel.
- R4: Every data and CRC bit begins with a falling edge of dout, and consecutive bit starts are exactly P cycles apart.
- R5: A bit value 1 holds dout low for T = floor(P/3) cycles. A bit value 0 holds it low for 2*T cycles. dout is high for the rest of the slot.
- R6: The data bits are sent as tx_data[N-1] down to tx_data[0] (bits above N-1 are unused), and then the L CRC bits.
- R7: N is data_len clamped to 9..16 and L is crc_len clamped to 1..8, so a frame has exactly N+L pulse-coded bits.
- R8: The CRC is an 8-bit register seeded with 8'hFF. For each data bit b in send order, f = c[7]^b and c becomes (c<<1) ^ (f ? 8'h07 : 8'h00). The transmitted CRC bits are c[7] down to c[8-L].
- R9: frame_n stays low for exactly (1+N+L)*P cycles and rises right after the last cycle of the final CRC slot.
- R10: The level of ret_in in the last cycle of each data slot is shifted into rx_data. The first data bit received lands in bit N-1, the last in bit 0, and bits above N-1 read 0.
- R11: rx_crc_err is 1 exactly when one or more of the L received CRC bits differ from the R8 CRC computed over the received data bits.
- R12: done is high for one cycle, in the second cycle of frame_n high after a frame. rx_data and rx_crc_err hold their final values from then until the next frame is accepted.
- R13: After a frame, with G the captured gap_cfg, frame_n stays high for at least max(G,2) cycles. With start held high, the next frame starts after exactly max(G,2) high cycles.
- R14: start while ready is low (during a frame or an unexpired gap) is ignored and produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock (bit timebase) |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame request, taken when ready is high |
| tx_data | input | 16 | Command word, right aligned |
| data_len | input | 5 | Requested data length (clamped to 9..16) |
| crc_len | input | 4 | Requested CRC length (clamped to 1..8) |
| period_sel | input | 8 | Bit period select, P = 320 + 2*period_sel |
| gap_cfg | input | 16 | Minimum frame_n high time after this frame, in cycles |
| ret_in | input | 1 | Return line from the bus |
| frame_n | output | 1 | Frame line, low during a frame |
| dout | output | 1 | Pulse-width coded data line |
| ready | output | 1 | A start on this edge would be accepted |
| done | output | 1 | One-cycle pulse, received word valid |
| rx_data | output | 16 | Received word, right aligned |
| rx_crc_err | output | 1 | Received CRC mismatch |

## Verification
Several rules are checked by assertions on every cycle. The data line is idle whenever the frame line is high. The phase stays inside the bit period, and the period select is held steady while a frame runs. A frame is never cut short. Each frame begins only from an accepted start. done is a single pulse at its fixed place after the frame line rises, and the received outputs stay unchanged between frames. The gap counter is checked as well. Pulse widths, bit order, CRC contents, clamping, lead and frame lengths, return sampling, error detection and the exact back-to-back gap depend on the data. They are shown only by bench scenarios that decode the line and compare it with independently computed frames, over random words, lengths and periods and over directed extremes.

// File: rtl/psb_pkg.sv
// Package: shared types of the pulse-width sensor bus frame engine.
// Assumes nothing beyond IEEE 1800-2017 enums.
package psb_pkg;

    // Frame controller states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } psb_state_e;

endpackage

// File: rtl/psb_bit_timer.sv
// Bit timer: counts the fast-clock phase within one bit slot and reports the
// last cycle of the slot, plus whether the phase is still inside the short
// (one third) or long (two thirds) low window.
// Assumes sel is held steady while run is high; the phase restarts at 0 on
// the first cycle of run.
module psb_bit_timer #(
    parameter int SEL_W    = 8,
    parameter int BASE_CYC = 320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             slot_end,
    output logic             low_short,
    output logic             low_long
);

    localparam int PER_MAX = BASE_CYC + 2 * ((1 << SEL_W) - 1);
    localparam int PH_W    = $clog2(PER_MAX + 1);

    logic [PH_W-1:0] period;
    logic [PH_W-1:0] third;
    logic [PH_W-1:0] ph_q;

    // Period and its rounded-down third from the select value.
    always_comb begin
        period = PH_W'(BASE_CYC) + (PH_W'(sel) << 1);
        third  = period / PH_W'(3);
    end

    // Phase counter, wraps at the end of each slot, parked at 0 when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (!run) begin
            ph_q <= '0;
        end else if (ph_q == period - 1'b1) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Slot end and low-window decode.
    always_comb begin
        slot_end  = run && (ph_q == period - 1'b1);
        low_short = ph_q < third;
        low_long  = ph_q < (third << 1);
    end

    AST_PHASE_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ph_q < period)); // R4
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(sel)); // R2

endmodule

// File: rtl/psb_crc_lfsr.sv
// CRC shift register: loads the seed, folds one bit per calc strobe with a
// fixed polynomial, and shifts plainly on a dump strobe so that its MSB
// presents the CRC bits in order.
// Assumes at most one strobe per cycle and W of at least 2.
module psb_crc_lfsr #(
    parameter int           W    = 8,
    parameter logic [W-1:0] POLY = 'h07,
    parameter logic [W-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         calc,
    input  logic         dump,
    input  logic         din,
    output logic [W-1:0] crc
);

    logic [W-1:0] crc_q;
    logic         fb;

    // Feedback bit of the folding step.
    always_comb fb = crc_q[W-1] ^ din;

    // CRC register update.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            crc_q <= SEED;
        end else if (calc) begin
            crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else if (dump) begin
            crc_q <= {crc_q[W-2:0], 1'b0};
        end
    end

    assign crc = crc_q;

    AST_CRC_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, calc, dump})); // R8

endmodule

// File: rtl/psb_gap_timer.sv
// Gap timer: counts frame-line high cycles after a frame and reports when
// the programmed minimum gap is within one cycle of being met.
// Assumes arm pulses on the edge that ends the frame and active is high
// for the whole gap state.
module psb_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             active,
    input  logic [GAP_W-1:0] gap_min,
    output logic             elapsed
);

    logic [GAP_W-1:0] cnt_q;

    // Elapsed once the next cycle would complete the minimum gap.
    always_comb elapsed = active && (({1'b0, cnt_q} + 1'b1) >= {1'b0, gap_min});

    // Gap cycle counter, restarted at each frame end, frozen once elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            cnt_q <= '0;
        end else if (active && !elapsed) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_GAP_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ({1'b0, cnt_q} <= {1'b0, gap_min})); // R13

endmodule

// File: rtl/psb_frame_engine.sv
// Frame engine top: accepts a frame request, runs the lead slot, the data
// slots and the CRC slots with pulse-width coding on dout, samples ret_in at
// the end of each slot, checks the received CRC, raises done and enforces
// the minimum gap before the next frame.
// Assumes clk is the fast internal clock and ret_in is already synchronous.
module psb_frame_engine #(
    parameter int DATA_MIN              = 9,
    parameter int DATA_MAX              = 16,
    parameter int CRC_MAX               = 8,
    parameter int SEL_W                 = 8,
    parameter int BASE_CYC              = 320,
    parameter int GAP_W                 = 16,
    parameter logic [CRC_MAX-1:0] CRC_POLY = 'h07,
    parameter logic [CRC_MAX-1:0] CRC_SEED = '1,
    parameter int LEN_W                 = $clog2(DATA_MAX + 1),
    parameter int CLEN_W                = $clog2(CRC_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DATA_MAX-1:0] tx_data,
    input  logic [LEN_W-1:0]    data_len,
    input  logic [CLEN_W-1:0]   crc_len,
    input  logic [SEL_W-1:0]    period_sel,
    input  logic [GAP_W-1:0]    gap_cfg,
    input  logic                ret_in,
    output logic                frame_n,
    output logic                dout,
    output logic                ready,
    output logic                done,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_crc_err
);

    import psb_pkg::*;

    localparam int SLOT_W = $clog2(DATA_MAX + CRC_MAX + 1);

    psb_state_e          state_q;
    logic [SLOT_W-1:0]   slot_q;
    logic [LEN_W-1:0]    dlen_c, dlen_q;
    logic [CLEN_W-1:0]   clen_c, clen_q;
    logic [SEL_W-1:0]    sel_q;
    logic [GAP_W-1:0]    gap_q;
    logic [DATA_MAX-1:0] tx_sh_q;
    logic [DATA_MAX-1:0] rx_sh_q;
    logic                err_q;
    logic                end_q;
    logic                done_q;

    logic                run, accept, gap_ok;
    logic                slot_end, low_short, low_long;
    logic                data_slot, crc_slot, last_slot, frame_end;
    logic                cur_bit;
    logic [SLOT_W-1:0]   dlen_s, last_s;
    logic [CRC_MAX-1:0]  tx_crc, rx_crc;

    // Clamp the requested lengths to their legal ranges.
    always_comb begin
        if (data_len < LEN_W'(DATA_MIN))      dlen_c = LEN_W'(DATA_MIN);
        else if (data_len > LEN_W'(DATA_MAX)) dlen_c = LEN_W'(DATA_MAX);
        else                                  dlen_c = data_len;
        if (crc_len == '0)                    clen_c = CLEN_W'(1);
        else if (crc_len > CLEN_W'(CRC_MAX))  clen_c = CLEN_W'(CRC_MAX);
        else                                  clen_c = crc_len;
    end

    // Slot classification from the slot counter and captured lengths.
    always_comb begin
        dlen_s    = SLOT_W'(dlen_q);
        last_s    = SLOT_W'(dlen_q) + SLOT_W'(clen_q);
        data_slot = (slot_q != '0) && (slot_q <= dlen_s);
        crc_slot  = slot_q > dlen_s;
        last_slot = slot_q == last_s;
        cur_bit   = data_slot ? tx_sh_q[DATA_MAX-1] : tx_crc[CRC_MAX-1];
        frame_end = slot_end && last_slot;
    end

    // Handshake decode: a start is taken when idle or when the gap is met.
    always_comb begin
        run    = (state_q == ST_RUN);
        ready  = (state_q == ST_IDLE) || ((state_q == ST_GAP) && gap_ok && !end_q);
        accept = start && ready;
    end

    // Frame state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) state_q <= ST_RUN;
                ST_RUN:  if (frame_end) state_q <= ST_GAP;
                ST_GAP: begin
                    if (accept)                 state_q <= ST_RUN;
                    else if (gap_ok && !end_q)  state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Per-frame configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlen_q <= LEN_W'(DATA_MAX);
            clen_q <= CLEN_W'(CRC_MAX);
            sel_q  <= '0;
            gap_q  <= '0;
        end else if (accept) begin
            dlen_q <= dlen_c;
            clen_q <= clen_c;
            sel_q  <= period_sel;
            gap_q  <= gap_cfg;
        end
    end

    // Slot counter: 0 is the lead slot, then data slots, then CRC slots.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            slot_q <= '0;
        end else if (slot_end) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Transmit shift register, MSB of the word in the top bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
        end else if (accept) begin
            tx_sh_q <= tx_data << (LEN_W'(DATA_MAX) - dlen_c);
        end else if (slot_end && data_slot) begin
            tx_sh_q <= {tx_sh_q[DATA_MAX-2:0], 1'b0};
        end
    end

    // Receive shift register and CRC error flag.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            rx_sh_q <= '0;
            err_q   <= 1'b0;
        end else if (slot_end && data_slot) begin
            rx_sh_q <= {rx_sh_q[DATA_MAX-2:0], ret_in};
        end else if (slot_end && crc_slot && (ret_in != rx_crc[CRC_MAX-1])) begin
            err_q   <= 1'b1;
        end
    end

    // Done pipeline: frame end, then one frame-high cycle, then done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            end_q  <= frame_end;
            done_q <= end_q;
        end
    end

    psb_bit_timer #(
        .SEL_W    (SEL_W),
        .BASE_CYC (BASE_CYC)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sel       (sel_q),
        .slot_end  (slot_end),
        .low_short (low_short),
        .low_long  (low_long)
    );

    psb_crc_lfsr #(
        .W    (CRC_MAX),
        .POLY (CRC_POLY),
        .SEED (CRC_SEED)
    ) tx_crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .calc  (slot_end && data_slot),
        .dump  (slot_end && crc_slot),
        .din   (cur_bit),
        .crc   (tx_crc)
    );

    psb_crc_lfsr #(
        .W    (CRC_MAX),
        .POLY (CRC_POLY),
        .SEED (CRC_SEED)
    ) rx_crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .calc  (slot_end && data_slot),
        .dump  (slot_end && crc_slot),
        .din   (ret_in),
        .crc   (rx_crc)
    );

    psb_gap_timer #(
        .GAP_W (GAP_W)
    ) gap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (frame_end),
        .active  (state_q == ST_GAP),
        .gap_min (gap_q),
        .elapsed (gap_ok)
    );

    // Line drivers.
    always_comb begin
        frame_n = !run;
        dout    = !(run && (slot_q != '0) && (cur_bit ? low_short : low_long));
    end

    assign done       = done_q;
    assign rx_data    = rx_sh_q;
    assign rx_crc_err = err_q;

    AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |-> dout); // R3
    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_end) |=> run); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_DONE_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (frame_n && $past(frame_n) && !$past(frame_n, 2))); // R12
    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !accept) |=> ($stable(rx_data) && $stable(rx_crc_err))); // R12
    AST_GAP_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_GAP) && !ready) |=> frame_n); // R13
    AST_START_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> ($past(start) && $past(ready))); // R14

endmodule

// File: tb/psb_frame_engine_tb_top.sv
`timescale 1ns/1ps
module psb_frame_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ret_in = 1'b1;
    logic [15:0] tx_data = '0;
    logic [4:0]  data_len = 5'd16;
    logic [3:0]  crc_len = 4'd8;
    logic [7:0]  period_sel = '0;
    logic [15:0] gap_cfg = '0;
    wire         frame_n, dout, ready, done, rx_crc_err;
    wire  [15:0] rx_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_rise = 0;
    int prev_gap = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    psb_frame_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
        .data_len(data_len), .crc_len(crc_len), .period_sel(period_sel),
        .gap_cfg(gap_cfg), .ret_in(ret_in), .frame_n(frame_n), .dout(dout),
        .ready(ready), .done(done), .rx_data(rx_data), .rx_crc_err(rx_crc_err)
    );

    task automatic chk(input bit ok, input string req, input longint act,
                       input longint exp, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int clamp_n(input int v);
        return (v < 9) ? 9 : (v > 16) ? 16 : v;
    endfunction

    function automatic int clamp_l(input int v);
        return (v < 1) ? 1 : (v > 8) ? 8 : v;
    endfunction

    // CRC over the low n bits of d, sent MSB first (R8).
    function automatic logic [7:0] crc_of(input logic [15:0] d, input int n);
        logic [7:0] c;
        logic       f;
        c = 8'hFF;
        for (int i = n - 1; i >= 0; i--) begin
            f = c[7] ^ d[i];
            c = {c[6:0], 1'b0} ^ (f ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    // Runs one frame and checks the line coding, sampling and result.
    task automatic run_frame(input logic [15:0] d, input int dl, input int cl,
                             input int sel, input int gap, input logic [15:0] resp,
                             input bit flip, input bit hold, input int exp_run,
                             input bit poke, input bit scramble);
        int n, l, p, t, hi, fall, rise, nb, fall_t, w;
        logic eb [0:23];
        logic rb [0:23];
        logic [7:0] tc, rc;
        logic prev_d, dec;
        bit poke_clr;
        n  = clamp_n(dl);
        l  = clamp_l(cl);
        p  = 320 + 2 * sel;
        t  = p / 3;
        tc = crc_of(d, n);
        rc = crc_of(resp, n);
        for (int i = 0; i < n; i++) begin
            eb[i] = d[n-1-i];
            rb[i] = resp[n-1-i];
        end
        for (int i = 0; i < l; i++) begin
            eb[n+i] = tc[7-i];
            rb[n+i] = rc[7-i];
        end
        if (flip) rb[n] = ~rb[n];
        if (!hold) while (!ready) @(negedge clk);
        tx_data = d; data_len = 5'(dl); crc_len = 4'(cl);
        period_sel = 8'(sel); gap_cfg = 16'(gap); start = 1'b1;
        hi = 0;
        forever begin
            @(negedge clk);
            if (!frame_n) break;
            hi++;
        end
        start = 1'b0;
        fall = cyc;
        if (!hold) chk(hi == 0, "R2", hi, 0, "cycles from accepted start to frame");
        else       chk(fall - last_rise == exp_run, "R13", fall - last_rise, exp_run, "frame_n high run");
        prev_d = 1'b1; nb = 0; fall_t = fall; poke_clr = 0;
        forever begin
            @(negedge clk);
            if (poke_clr) begin start = 1'b0; poke_clr = 0; end
            if (frame_n) begin
                rise = cyc;
                break;
            end
            if (!dout && prev_d) begin
                if (nb == 0) chk(cyc - fall == p, "R3", cyc - fall, p, "lead slot length");
                else         chk(cyc - fall_t == p, "R4", cyc - fall_t, p, "bit period");
                fall_t = cyc;
                if (nb < 24) ret_in = rb[nb];
                nb++;
                if (scramble && nb == 2) begin
                    tx_data = 16'($urandom); period_sel = 8'($urandom);
                    data_len = 5'($urandom); crc_len = 4'($urandom);
                end
                if (poke && nb == 3) begin start = 1'b1; poke_clr = 1; end
            end
            if (dout && !prev_d) begin
                w = cyc - fall_t;
                chk(w == t || w == 2 * t, "R5", w, t, "low pulse width");
                dec = (w == t);
                if (nb - 1 < n) chk(dec == eb[nb-1], "R6", dec, eb[nb-1], "data bit");
                else if (nb - 1 < 24) chk(dec == eb[nb-1], "R8", dec, eb[nb-1], "crc bit");
            end
            prev_d = dout;
        end
        chk(nb == n + l, "R7", nb, n + l, "bit count");
        chk(rise - fall == (1 + n + l) * p, "R9", rise - fall, (1 + n + l) * p, "frame length");
        chk(done == 1'b0, "R12", done, 0, "done on rise cycle");
        last_rise = rise;
        ret_in = 1'b1;
        @(negedge clk);
        chk(done == 1'b1, "R12", done, 1, "done one cycle after rise");
        chk(rx_data == (resp & 16'((32'h1 << n) - 1)), "R10", rx_data,
            resp & 16'((32'h1 << n) - 1), "received word");
        chk(rx_crc_err == flip, "R11", rx_crc_err, flip, "crc error flag");
        @(negedge clk);
        chk(done == 1'b0, "R12", done, 0, "done width");
        prev_gap = gap;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int g;
        void'($urandom(32'd5171));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(frame_n == 1 && dout == 1, "R1", {frame_n, dout}, 3, "lines after reset");
        chk(ready == 1 && done == 0, "R1", {ready, done}, 2, "ready/done after reset");
        chk(rx_data == 0 && rx_crc_err == 0, "R1", rx_data, 0, "rx after reset");

        // Full length, fastest period, clean response.
        run_frame(16'hA5C3, 16, 8, 0, 10, 16'h3C96, 0, 0, 0, 0, 0);
        // Length clamps (R7): short data and zero CRC length.
        run_frame(16'hFFFF, 3, 0, 2, 10, 16'h0155, 0, 0, 0, 0, 0);
        // Length clamps (R7): oversize data and CRC length.
        run_frame(16'h1234, 20, 12, 1, 10, 16'hBEEF, 0, 0, 0, 0, 0);
        // Slowest period (P = 830).
        run_frame(16'h0133, 9, 1, 255, 10, 16'h00AA, 0, 0, 0, 0, 0);
        // Corrupted return CRC (R11).
        run_frame(16'h0F0F, 12, 5, 3, 10, 16'h0A5A, 1, 0, 0, 0, 0);
        // Start during a frame is ignored (R14).
        run_frame(16'h02D4, 10, 3, 1, 5, 16'h0311, 0, 0, 0, 1, 0);
        begin
            bit stayed;
            stayed = 1;
            repeat (40) begin
                @(negedge clk);
                if (!frame_n) stayed = 0;
            end
            chk(stayed, "R14", stayed, 1, "no frame from ignored start");
        end
        // Random frames, alternating back-to-back with held start (R13)
        // and input scrambling during the frame (R2).
        for (int k = 0; k < 8; k++) begin
            g = 4 + int'($urandom_range(296));
            run_frame(16'($urandom), 9 + int'($urandom_range(7)), 1 + int'($urandom_range(7)),
                      int'($urandom_range(20)), g, 16'($urandom), bit'($urandom_range(1)),
                      (k % 2) == 1, prev_gap, 0, (k % 2) == 0);
        end
        summary();
    end

endmodule